// File: doc/BRIEF.md
# Flash Program/Erase Completion Poller

This block runs on the host side of a parallel flash. Once software or a sequencer has issued the last command write of a word program or an erase, it pulses `start_i`. The poller then reads one flash location over and over through a synchronous request/acknowledge read port until the status bits show that the internal operation has finished. It reports the end of the operation with a one-cycle `done_o` pulse, or with a one-cycle `error_o` pulse if a cycle budget runs out first.

Two detection methods are available, and `method_i` selects one for each run. In data-polling mode (`method_i`=0), bit 7 of each read is compared with an expected value. For a program (`erase_i`=0) the expected value is bit 7 of the word that was written. For an erase (`erase_i`=1) it is 1. In toggle mode (`method_i`=1), bit 6 of each read is compared with bit 6 of the read before it, and an equal pair means the operation has finished. Completion inside the flash is asynchronous to the reads, so a status sample can catch a transition. For this reason a failing read is never final: the poller issues two confirmation reads. If both pass, the run is complete. If either fails, ordinary polling resumes.

The controller has four states. ST_IDLE moves to ST_POLL on start. In ST_POLL, a passing read finishes the run, a failing read goes to ST_CONF1, and a timeout goes to ST_IDLE. In ST_CONF1, a passing read goes to ST_CONF2 and a failing read returns to ST_POLL. In ST_CONF2, a passing read finishes the run and a failing read returns to ST_POLL. Every non-idle state also goes to ST_IDLE on timeout.

Top module: `flash_done_poller`

## Requirements
- R1: After reset, `busy_o`, `rd_req_o`, `done_o` and `error_o` are all 0.
- R2: A `start_i` pulse seen while idle latches `addr_i`, `method_i`, `erase_i`, bit 7 of `wdata_i` and the limit for the operation. `rd_addr_o` then carries the latched address, and later changes on `addr_i` do not affect it. `rd_req_o` stays high and `rd_addr_o` stays stable until `rd_ack_i`. Each ack ends one read, and the next read is requested from the following cycle.
- R3: Data polling, program: a read whose bit 7 equals bit 7 of `wdata_i` passes. Bit 6 and all other bits are ignored.
- R4: Data polling, erase: a read whose bit 7 is 1 passes.
- R5: Toggle mode: a read passes when its bit 6 equals bit 6 of the previous read of the same run. The first read of a run only sets the reference. Bit 7 and the operation type are ignored.
- R6: In ST_POLL a passing read completes the run. A failing read starts two confirmation reads. Completion follows only if both pass. A failing confirmation read returns the poller to polling.
- R7: The run is limited to `prog_limit_i` busy cycles for a program and `erase_limit_i` for an erase. When the limit is used up without completion, `error_o` pulses, the read request drops and the poller goes idle. A limit of 0 behaves as 1.
- R8: `start_i` has no effect while `busy_o` is high.
- R9: `done_o` and `error_o` are single-cycle pulses that are never high together. `busy_o` is already low in the cycle of either pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin polling (accepted only when idle) |
| method_i | input | 1 | 0 = bit-7 data polling, 1 = bit-6 toggle |
| erase_i | input | 1 | 0 = program, 1 = erase |
| addr_i | input | AW (20) | Location to poll |
| wdata_i | input | DW (16) | Word that was programmed |
| prog_limit_i | input | TW (24) | Cycle budget for a program |
| erase_limit_i | input | TW (24) | Cycle budget for an erase |
| rd_req_o | output | 1 | Read request, held until ack |
| rd_addr_o | output | AW (20) | Read address |
| rd_ack_i | input | 1 | Read response strobe |
| rd_data_i | input | DW (16) | Read data, valid with ack |
| busy_o | output | 1 | Polling in progress |
| done_o | output | 1 | Completion pulse |
| error_o | output | 1 | Timeout pulse |

## Verification
The bench feeds read sequences in which a failing read is followed by a single passing read and then another failure. A poller that finishes on one passing confirmation read, or that never returns to polling, ends after the wrong number of reads. Toggle sequences change bit 7 while bit 6 stays put, and polling sequences do the reverse. A design that watches the wrong bit, or that judges the first toggle read against reset state, therefore miscounts. Timeout runs measure the exact number of busy cycles for both operation types and for a zero limit. One of these runs also fires a second start mid-run, which exposes a design that restarts its timer or switches its operation.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_POLL,
        ST_CONF1,
        ST_CONF2
    } poll_state_t;
endpackage

// File: rtl/poll_judge.sv
// Decides whether one status read passes, for either detection method.
module poll_judge #(
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6
) (
    input  logic method,     // 0: data polling, 1: toggle
    input  logic exp_bit,    // expected polling bit
    input  logic ref_bit,    // toggle bit of the previous read
    input  logic poll_bit,   // polling bit of this read
    input  logic tog_bit,    // toggle bit of this read
    output logic pass
);
    always_comb begin
        if (method) pass = (tog_bit == ref_bit);
        else        pass = (poll_bit == exp_bit);
    end
endmodule

// File: rtl/poll_timer.sv
// Counts busy cycles and flags the cycle in which the budget is used up.
module poll_timer #(
    parameter int TW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [TW-1:0] limit,
    output logic          expire
);
    localparam int CW = TW + 1;

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else                cnt_q <= cnt_q + 1'b1;
    end

    assign expire = run && (({1'b0, cnt_q} + CW'(1)) >= {1'b0, limit});

    // R7: the count never passes the limit while running
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && limit != '0) |-> (cnt_q < limit));
endmodule

// File: rtl/flash_done_poller.sv
module flash_done_poller
    import flash_poll_pkg::*;
#(
    parameter int AW       = 20,
    parameter int DW       = 16,
    parameter int TW       = 24,
    parameter int POLL_BIT = 7,
    parameter int TOG_BIT  = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          method_i,
    input  logic          erase_i,
    input  logic [AW-1:0] addr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [TW-1:0] prog_limit_i,
    input  logic [TW-1:0] erase_limit_i,
    output logic          rd_req_o,
    output logic [AW-1:0] rd_addr_o,
    input  logic          rd_ack_i,
    input  logic [DW-1:0] rd_data_i,
    output logic          busy_o,
    output logic          done_o,
    output logic          error_o
);
    poll_state_t   state_q, state_d;
    logic [AW-1:0] addr_q;
    logic [TW-1:0] limit_q;
    logic          method_q, exp_q, ref_q, have_ref_q;
    logic          done_q, err_q;
    logic          pass, judged, expire, active;
    logic          fin_ok, fin_to;

    assign active = (state_q != ST_IDLE);

    poll_judge #(.POLL_BIT(POLL_BIT), .TOG_BIT(TOG_BIT)) u_judge (
        .method   (method_q),
        .exp_bit  (exp_q),
        .ref_bit  (ref_q),
        .poll_bit (rd_data_i[POLL_BIT]),
        .tog_bit  (rd_data_i[TOG_BIT]),
        .pass     (pass)
    );

    poll_timer #(.TW(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (active),
        .limit  (limit_q),
        .expire (expire)
    );

    // A read is judged on ack, except the first read of a toggle run.
    assign judged = active && rd_ack_i && (!method_q || have_ref_q);
    assign fin_ok = judged && pass && (state_q == ST_POLL || state_q == ST_CONF2);
    assign fin_to = active && expire && !fin_ok;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_POLL;
            ST_POLL: begin
                if (fin_ok || fin_to) state_d = ST_IDLE;
                else if (judged)      state_d = ST_CONF1;
            end
            ST_CONF1: begin
                if (fin_to)      state_d = ST_IDLE;
                else if (judged) state_d = pass ? ST_CONF2 : ST_POLL;
            end
            ST_CONF2: begin
                if (fin_ok || fin_to) state_d = ST_IDLE;
                else if (judged)      state_d = ST_POLL;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            limit_q    <= '0;
            method_q   <= 1'b0;
            exp_q      <= 1'b0;
            ref_q      <= 1'b0;
            have_ref_q <= 1'b0;
            done_q     <= 1'b0;
            err_q      <= 1'b0;
        end else begin
            done_q <= fin_ok;
            err_q  <= fin_to;
            if (state_q == ST_IDLE) begin
                if (start_i) begin
                    addr_q     <= addr_i;
                    method_q   <= method_i;
                    exp_q      <= erase_i ? 1'b1 : wdata_i[POLL_BIT];
                    limit_q    <= erase_i ? erase_limit_i : prog_limit_i;
                    have_ref_q <= 1'b0;
                end
            end else if (rd_ack_i) begin
                ref_q      <= rd_data_i[TOG_BIT];
                have_ref_q <= 1'b1;
            end
        end
    end

    assign rd_req_o  = active;
    assign rd_addr_o = addr_q;
    assign busy_o    = active;
    assign done_o    = done_q;
    assign error_o   = err_q;

    logic unused_bits;
    assign unused_bits = ^{rd_data_i, wdata_i};

    // R9: outcome pulses are exclusive and single-cycle
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && error_o));
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    p_err_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |=> !error_o);
    p_idle_at_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || error_o) |-> !busy_o);
    // R2: request held until ack unless the run timed out
    p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> (rd_req_o || error_o));
    p_addr_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_ack_i) |=> $stable(rd_addr_o));
endmodule

// File: tb/flash_done_poller_test.sv
`timescale 1ns/1ps
module flash_done_poller_test;
    localparam int AW = 20, DW = 16, TW = 24;

    typedef struct packed {
        logic             tog;
        logic             ers;
        logic [15:0]      wd;
        logic [2:0]       n;
        logic [0:5][15:0] rd;
        logic [2:0]       exp_n;
    } vec_t;

    localparam vec_t VECS [9] = '{
        '{1'b0, 1'b0, 16'h0080, 3'd3, '{16'h0000, 16'h0080, 16'h0080, 16'h0, 16'h0, 16'h0}, 3'd3},
        '{1'b0, 1'b0, 16'h0012, 3'd4, '{16'h0092, 16'h0012, 16'h0092, 16'h0012, 16'h0, 16'h0}, 3'd4},
        '{1'b0, 1'b1, 16'h1234, 3'd1, '{16'hFFFF, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0}, 3'd1},
        '{1'b0, 1'b1, 16'h0000, 3'd3, '{16'h0000, 16'h0000, 16'hFFFF, 16'h0, 16'h0, 16'h0}, 3'd3},
        '{1'b1, 1'b0, 16'h0000, 3'd6, '{16'h0040, 16'h0000, 16'h0040, 16'h0000, 16'h0000, 16'h0000}, 3'd6},
        '{1'b1, 1'b1, 16'h0000, 3'd2, '{16'h0040, 16'h0040, 16'h0, 16'h0, 16'h0, 16'h0}, 3'd2},
        '{1'b1, 1'b0, 16'h0000, 3'd4, '{16'h0000, 16'h0040, 16'h0040, 16'h0040, 16'h0, 16'h0}, 3'd4},
        '{1'b1, 1'b0, 16'h0000, 3'd2, '{16'h0080, 16'h0000, 16'h0, 16'h0, 16'h0, 16'h0}, 3'd2},
        '{1'b0, 1'b0, 16'h00FF, 3'd1, '{16'h00BF, 16'h0, 16'h0, 16'h0, 16'h0, 16'h0}, 3'd1}
    };

    logic          clk = 1'b0, rst_n = 1'b0;
    logic          start = 1'b0, method = 1'b0, erase = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [TW-1:0] plim = 24'd1000, elim = 24'd1000;
    logic          rd_req, rd_ack = 1'b0, busy, done, error;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data = '0;

    logic [15:0] scr [6];
    logic [15:0] dflt = 16'h0000;
    int          scr_n = 0, scr_idx = 0;
    logic        scr_clr = 1'b0;
    int          nchk = 0, nfail = 0, cyc = 0;

    always #10 clk = ~clk;

    flash_done_poller #(.AW(AW), .DW(DW), .TW(TW)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .method_i(method),
        .erase_i(erase), .addr_i(addr), .wdata_i(wdata),
        .prog_limit_i(plim), .erase_limit_i(elim),
        .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(rd_ack),
        .rd_data_i(rd_data), .busy_o(busy), .done_o(done), .error_o(error)
    );

    // Read responder: answers a held request every other cycle from a script.
    always @(posedge clk) begin
        if (scr_clr) begin
            scr_idx <= 0;
            rd_ack  <= 1'b0;
        end else begin
            rd_ack <= rd_req && !rd_ack;
            if (rd_req && !rd_ack) begin
                rd_data <= (scr_idx < scr_n) ? scr[scr_idx] : dflt;
                scr_idx <= scr_idx + 1;
            end
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            nfail = nfail + 1;
            $display("FAIL watchdog: actual %0d cycles, expected fewer", cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        nchk = nchk + 1;
        if (!ok) begin
            nfail = nfail + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic launch(input bit tg, input bit er, input logic [15:0] wd);
        @(negedge clk) scr_clr = 1'b1;
        @(negedge clk) scr_clr = 1'b0;
        method = tg; erase = er; wdata = wd; start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    // Counts busy samples until error; optional second start mid-run.
    task automatic timeout_run(input bit er, input string tag, input int exp_cnt, input bit restart);
        int  cnt = 0;
        bit  saw_done = 0;
        launch(1'b0, er, 16'h0080);
        for (int i = 0; i < 2000; i++) begin
            if (error) break;
            if (done) saw_done = 1;
            if (busy) cnt++;
            if (restart && i == 4) begin
                erase = ~er; start = 1'b1; addr = addr + 1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        start = 1'b0;
        check(error === 1'b1, tag, error, 1);
        check(cnt == exp_cnt, tag, cnt, exp_cnt);
        check(!saw_done, tag, saw_done, 0);
    endtask

    initial begin
        scr_n = 0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(busy === 1'b0 && rd_req === 1'b0, "R1 busy/req", busy + rd_req, 0);
        check(done === 1'b0 && error === 1'b0, "R1 done/err", done + error, 0);
        rst_n = 1'b1;
        @(negedge clk);

        foreach (VECS[k]) begin
            vec_t v = VECS[k];
            string tag;
            bit got_done = 0, got_err = 0;
            tag = v.tog ? "R5" : (v.ers ? "R4" : "R3");
            if (v.exp_n > 1) tag = {tag, "/R6"};
            for (int j = 0; j < 6; j++) scr[j] = v.rd[j];
            scr_n = v.n;
            dflt = 16'h0000;
            addr = AW'(20'h1000 + k);
            launch(v.tog, v.ers, v.wd);
            for (int i = 0; i < 200; i++) begin
                if (done || error) begin got_done = done; got_err = error; break; end
                @(negedge clk);
            end
            check(got_done && !got_err, tag, got_done, 1);
            check(scr_idx == int'(v.exp_n), tag, scr_idx, v.exp_n);
            @(negedge clk);
            // R9: done lasts one cycle and busy is low
            check(done === 1'b0 && busy === 1'b0, "R9 pulse", done + busy, 0);
        end

        // R2: address latched, later input changes ignored
        scr_n = 0; plim = 24'd20; elim = 24'd12;
        addr = 20'h5A5A5;
        launch(1'b0, 1'b0, 16'h0080);
        addr = 20'h00001;
        repeat (3) @(negedge clk);
        check(rd_addr == 20'h5A5A5 && rd_req, "R2 addr", rd_addr, 20'h5A5A5);
        for (int i = 0; i < 100 && !error; i++) @(negedge clk);
        @(negedge clk);

        // R7: program and erase budgets; R8: start ignored mid-run
        timeout_run(1'b0, "R7 prog", 20, 1'b0);
        timeout_run(1'b1, "R7 erase", 12, 1'b0);
        timeout_run(1'b0, "R8 restart", 20, 1'b1);
        plim = 24'd0;
        timeout_run(1'b0, "R7 zero", 1, 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule